// File: doc/BRIEF.md
# Adaptive Link Poll and Reset Scheduler

This block decides when a management agent should sample the link status of a single-pair Ethernet PHY and when that PHY should be reset. It counts time in units of an external millisecond tick. When a sample is due it raises a one-cycle poll strobe. The current link status is taken in the same cycle as the tick on which the sample falls due. A sample that finds the link up schedules the next one after a long, relaxed interval. A sample that finds the link down raises a one-cycle reset request.

The gap after a failed sample depends on how long the link has been down. The down time is counted from the first failed sample in an unbroken run of failures. Early in the outage the scheduler polls densely. Once the outage reaches a configurable window, it falls back to a sparse interval. Every reset is followed by a hold-off before the interval starts to count. The length of the hold-off depends on the master or slave role. Two partners running the same scheduler therefore drift apart and do not reset in lockstep forever.

All intervals, both hold-offs and the dense-poll window are parameters. A 2-bit regime output shows which interval the last sample selected.

Top module: `linkpoll_sched`

## Requirements
- R1: A poll that finds `link_up` high makes the next poll fall on the UP_MS-th tick after it and sets `regime_o` to 2'b01. No hold-off applies.
- R2: A poll that finds the link down, with a down time below FAST_WIN_MS ticks, selects the interval FAST_MS and sets `regime_o` to 2'b10.
- R3: A poll that finds the link down, with a down time of FAST_WIN_MS ticks or more, selects the interval SLOW_MS and sets `regime_o` to 2'b11.
- R4: The down time is the number of ticks since the first down poll of the current outage, and that first down poll counts as zero. Only a poll that sees the link up ends the outage. The count saturates and never wraps back below the window.
- R5: Every poll that finds the link down raises `phy_rst_req_o` for exactly one cycle, together with `poll_o`. A poll that finds the link up never raises it.
- R6: After a down poll, the interval starts counting only after a hold-off: HOLD_SLAVE_MS ticks when `role_slave` was 1 at that poll, and HOLD_MASTER_MS ticks when it was 0. A later change of `role_slave` has no effect on the hold-off already running.
- R7: An interval parameter of zero behaves as one tick, so the next poll is never on the same tick.
- R8: `poll_o` is high for one cycle, in the cycle after a tick on which a poll is due, and never without a tick.
- R9: The synchronous reset `rst` clears both strobes, sets `regime_o` to 2'b00, forgets any outage, and makes the first tick after reset a poll.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle time-base pulse, one per millisecond |
| link_up | input | 1 | Link status, sampled on the tick of a due poll |
| role_slave | input | 1 | 1 = slave role, 0 = master role; selects the hold-off |
| poll_o | output | 1 | One-cycle strobe: sample the link status now |
| phy_rst_req_o | output | 1 | One-cycle PHY reset request after a down poll |
| regime_o | output | 2 | 00 no poll yet, 01 up, 10 dense down, 11 sparse down |

## Verification
The assertions check the cycle-level rules on every cycle. A reset request appears only together with a poll and only in a down regime. Polls follow ticks. The regime changes only at a poll, and the no-poll-yet regime never carries a reset request. The bench scenarios cover the timing. They show the exact gap between polls in each regime, the role-dependent hold-off and the moment the regime falls back to sparse polling. They also show that the outage count saturates over a long outage, that a reset forgets the outage, and that a zero interval is raised to one tick.

// File: rtl/linkpoll_pkg.sv
package linkpoll_pkg;

    typedef enum logic [1:0] {
        REG_NONE = 2'b00,
        REG_UP   = 2'b01,
        REG_FAST = 2'b10,
        REG_SLOW = 2'b11
    } regime_e;

    typedef struct packed {
        logic    poll;
        logic    rreq;
        regime_e regime;
    } sched_t;

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/linkpoll_countdown.sv
module linkpoll_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (dec && (cnt_q != '0))
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/linkpoll_down_timer.sv
module linkpoll_down_timer #(
    parameter int W   = 13,
    parameter int SAT = 6000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         start,
    input  logic         clear,
    output logic         armed_o,
    output logic [W-1:0] span_o
);
    localparam logic [W-1:0] SAT_V = W'(SAT);

    logic         armed_d, armed_q;
    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] bump;

    always_comb begin
        bump    = (cnt_q >= SAT_V) ? cnt_q : cnt_q + 1'b1;
        armed_d = armed_q;
        cnt_d   = cnt_q;
        if (clear) begin
            armed_d = 1'b0;
            cnt_d   = '0;
        end else if (start) begin
            armed_d = 1'b1;
            cnt_d   = '0;
        end else if (tick && armed_q) begin
            cnt_d   = bump;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            armed_q <= armed_d;
            cnt_q   <= cnt_d;
        end
    end

    assign armed_o = armed_q;
    assign span_o  = (tick && armed_q) ? bump : cnt_q;
endmodule

// File: rtl/linkpoll_sched.sv
module linkpoll_sched
    import linkpoll_pkg::*;
#(
    parameter int UP_MS          = 421,
    parameter int FAST_MS        = 149,
    parameter int SLOW_MS        = 1117,
    parameter int FAST_WIN_MS    = 6000,
    parameter int HOLD_MASTER_MS = 97,
    parameter int HOLD_SLAVE_MS  = 149
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ms_tick,
    input  logic       link_up,
    input  logic       role_slave,
    output logic       poll_o,
    output logic       phy_rst_req_o,
    output logic [1:0] regime_o
);
    localparam int UP_L   = at_least_one(UP_MS);
    localparam int FAST_L = at_least_one(FAST_MS);
    localparam int SLOW_L = at_least_one(SLOW_MS);
    localparam int MAXV   = max2(max2(UP_L, max2(FAST_L, SLOW_L)),
                                 max2(HOLD_MASTER_MS, HOLD_SLAVE_MS));
    localparam int WW     = $clog2(MAXV + 1);
    localparam int DW     = (FAST_WIN_MS < 1) ? 1 : $clog2(FAST_WIN_MS + 1);

    localparam logic [WW-1:0] UP_LD   = WW'(UP_L - 1);
    localparam logic [WW-1:0] FAST_LD = WW'(FAST_L - 1);
    localparam logic [WW-1:0] SLOW_LD = WW'(SLOW_L - 1);
    localparam logic [WW-1:0] HOLD_M  = WW'(HOLD_MASTER_MS);
    localparam logic [WW-1:0] HOLD_S  = WW'(HOLD_SLAVE_MS);
    localparam logic [DW-1:0] WIN_V   = DW'(FAST_WIN_MS);

    sched_t        st_d, st_q;
    logic          hold_zero, wait_zero;
    logic          poll_due, down_poll, up_poll, go_fast;
    logic          dn_armed;
    logic [DW-1:0] dn_span, elapsed;
    logic [WW-1:0] wait_val, hold_val;

    // hold-off after a reset request; counts first
    linkpoll_countdown #(.W(WW)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (down_poll),
        .load_val (hold_val),
        .dec      (ms_tick),
        .zero_o   (hold_zero)
    );

    // poll interval; counts only once the hold-off is spent
    linkpoll_countdown #(.W(WW)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (poll_due),
        .load_val (wait_val),
        .dec      (ms_tick && hold_zero),
        .zero_o   (wait_zero)
    );

    linkpoll_down_timer #(.W(DW), .SAT(FAST_WIN_MS)) u_down (
        .clk     (clk),
        .rst     (rst),
        .tick    (ms_tick),
        .start   (down_poll && !dn_armed),
        .clear   (up_poll),
        .armed_o (dn_armed),
        .span_o  (dn_span)
    );

    always_comb begin
        poll_due  = ms_tick && hold_zero && wait_zero;
        down_poll = poll_due && !link_up;
        up_poll   = poll_due && link_up;
        elapsed   = dn_armed ? dn_span : '0;
        go_fast   = (elapsed < WIN_V);
        hold_val  = role_slave ? HOLD_S : HOLD_M;

        if (link_up)      wait_val = UP_LD;
        else if (go_fast) wait_val = FAST_LD;
        else              wait_val = SLOW_LD;

        st_d        = st_q;
        st_d.poll   = poll_due;
        st_d.rreq   = down_poll;
        if (up_poll)
            st_d.regime = REG_UP;
        else if (down_poll)
            st_d.regime = go_fast ? REG_FAST : REG_SLOW;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{poll: 1'b0, rreq: 1'b0, regime: REG_NONE};
        else     st_q <= st_d;
    end

    assign poll_o        = st_q.poll;
    assign phy_rst_req_o = st_q.rreq;
    assign regime_o      = st_q.regime;
endmodule

// File: rtl/linkpoll_sched_chk.sv
module linkpoll_sched_chk (
    input logic       clk,
    input logic       rst,
    input logic       ms_tick,
    input logic       poll_o,
    input logic       phy_rst_req_o,
    input logic [1:0] regime_o
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R5: a reset request only comes with a poll
    p_req_with_poll_r5: assert property (@(posedge clk) disable iff (rst)
        phy_rst_req_o |-> poll_o);

    // R5: a reset request only with a down regime (10 or 11)
    p_req_down_regime_r5: assert property (@(posedge clk) disable iff (rst)
        phy_rst_req_o |-> regime_o[1]);

    // R8: a poll follows a tick in the previous cycle
    p_poll_after_tick_r8: assert property (@(posedge clk) disable iff (rst)
        (poll_o && !rst_d) |-> $past(ms_tick));

    // R9: regime moves only at a poll
    p_regime_at_poll_r9: assert property (@(posedge clk) disable iff (rst)
        (!poll_o && !rst_d) |-> $stable(regime_o));

    // R9: no poll yet means no reset request
    p_none_no_req_r9: assert property (@(posedge clk) disable iff (rst)
        (regime_o == 2'b00) |-> !phy_rst_req_o);
endmodule

bind linkpoll_sched linkpoll_sched_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ms_tick       (ms_tick),
    .poll_o        (poll_o),
    .phy_rst_req_o (phy_rst_req_o),
    .regime_o      (regime_o)
);

// File: tb/linkpoll_sched_test.sv
`timescale 1ns/1ps
module linkpoll_sched_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ms_tick = 1'b0;
    logic link_up = 1'b1;
    logic role_slave = 1'b0;
    logic poll, req, mpoll, mreq;
    logic [1:0] regime, mregime;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;
    logic s_poll, s_req, s_after, s_mpoll;
    logic [1:0] s_reg;

    always #10 clk = ~clk;

    linkpoll_sched #(
        .UP_MS(5), .FAST_MS(3), .SLOW_MS(8), .FAST_WIN_MS(10),
        .HOLD_MASTER_MS(2), .HOLD_SLAVE_MS(4)
    ) uut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .link_up(link_up),
        .role_slave(role_slave), .poll_o(poll), .phy_rst_req_o(req),
        .regime_o(regime)
    );

    linkpoll_sched #(
        .UP_MS(0), .FAST_MS(0), .SLOW_MS(0), .FAST_WIN_MS(10),
        .HOLD_MASTER_MS(0), .HOLD_SLAVE_MS(0)
    ) uut_min (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .link_up(link_up),
        .role_slave(role_slave), .poll_o(mpoll), .phy_rst_req_o(mreq),
        .regime_o(mregime)
    );

    typedef struct packed {
        logic       link;
        logic       slave;
        logic [7:0] gap;
        logic       req;
        logic [1:0] regime;
    } vec_t;

    localparam int N_VEC = 11;
    localparam vec_t VEC [N_VEC] = '{
        '{1'b1, 1'b0, 8'd1,  1'b0, 2'b01},
        '{1'b1, 1'b0, 8'd5,  1'b0, 2'b01},
        '{1'b0, 1'b0, 8'd5,  1'b1, 2'b10},
        '{1'b0, 1'b0, 8'd5,  1'b1, 2'b10},
        '{1'b0, 1'b0, 8'd5,  1'b1, 2'b11},
        '{1'b0, 1'b1, 8'd10, 1'b1, 2'b11},
        '{1'b1, 1'b1, 8'd12, 1'b0, 2'b01},
        '{1'b0, 1'b1, 8'd5,  1'b1, 2'b10},
        '{1'b0, 1'b1, 8'd7,  1'b1, 2'b10},
        '{1'b0, 1'b0, 8'd7,  1'b1, 2'b11},
        '{1'b1, 1'b0, 8'd10, 1'b0, 2'b01}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    // one tick: pulse, sample results one cycle later, then the cycle after
    task automatic do_tick;
        @(negedge clk) ms_tick = 1'b1;
        @(negedge clk) ms_tick = 1'b0;
        s_poll  = poll;
        s_req   = req;
        s_reg   = regime;
        s_mpoll = mpoll;
        @(negedge clk);
        s_after = poll | req;
    endtask

    task automatic run_to_poll(output int gap);
        gap = 0;
        s_poll = 1'b0;
        while (!s_poll && gap < 200) begin
            do_tick();
            gap++;
        end
    endtask

    function automatic string reg_tag(input logic [1:0] r);
        case (r)
            2'b01:   return "R1";
            2'b10:   return "R2";
            default: return "R3";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int gap;
        int seen;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 reset poll", poll, 0);
        chk("R9 reset req", req, 0);
        chk("R9 reset regime", regime, 0);
        rst = 1'b0;

        for (int i = 0; i < N_VEC; i++) begin
            link_up    = VEC[i].link;
            role_slave = VEC[i].slave;
            run_to_poll(gap);
            chk($sformatf("%s gap vec%0d", VEC[i].link ? "R1" : "R6", i),
                gap, int'(VEC[i].gap));
            chk($sformatf("R5 req vec%0d", i), s_req, VEC[i].req);
            chk($sformatf("%s regime vec%0d", reg_tag(VEC[i].regime), i),
                s_reg, VEC[i].regime);
            chk($sformatf("R8 one cycle vec%0d", i), s_after, 0);
        end

        // R4 saturation: a long outage stays sparse
        link_up = 1'b0;
        role_slave = 1'b0;
        for (int k = 0; k < 6; k++) begin
            run_to_poll(gap);
            if (k >= 3) begin
                chk($sformatf("R4 sat gap%0d", k), gap, 10);
                chk($sformatf("R4 sat regime%0d", k), s_reg, 3);
            end
        end

        // R9 reset mid-outage: forgets outage, polls on first tick
        do_tick();
        do_tick();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        chk("R9 mid reset regime", regime, 0);
        chk("R9 mid reset req", req, 0);
        rst = 1'b0;
        do_tick();
        chk("R9 first tick poll", s_poll, 1);
        chk("R5 first tick req", s_req, 1);
        chk("R4 outage cleared regime", s_reg, 2);

        // R6 role change during the hold-off is ignored
        role_slave = 1'b1;
        run_to_poll(gap);
        chk("R6 hold uses role at poll", gap, 5);
        chk("R2 after role change", s_reg, 2);

        // R8 no poll without ticks
        seen = 0;
        repeat (30) begin
            @(negedge clk);
            if (poll || req) seen++;
        end
        chk("R8 idle no poll", seen, 0);

        // R7 zero intervals become one tick
        link_up = 1'b1;
        for (int k = 0; k < 3; k++) begin
            do_tick();
            chk($sformatf("R7 min interval tick%0d", k), s_mpoll, 1);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule